// File: doc/BRIEF.md
# Tearing-Effect Line Trigger

This block watches the tearing-effect signalling of an attached display and turns it into a single start strobe for a frame transfer engine. The display reports its scan position with a horizontal sync pulse per line and a vertical sync pulse per frame. These arrive either on two separate pins or multiplexed onto one pin. In the one-pin case the two kinds differ only in duration. The block synchronises each pin into the local clock, applies a per-signal polarity, and measures how many clock ticks each pulse stays active. From those widths it decides what each pulse was.

A line counter is cleared by each vertical sync and advances on each horizontal sync. When the count reaches a programmed 11-bit line number, the block emits one start strobe for that frame. The strobe is what the transfer engine waits on, so writes into display memory can trail the scan and no tear shows. With the mode set to off the block stays quiet and holds its counter at zero.

Top module: `te_line_trigger`

## Requirements
- R1: While reset is asserted and directly after it, `line_o` is 0 and `start_o` is low.
- R2: In one-pin mode (`cfg_mode` = 1), an active pulse on `te_a_i` lasting at least `vs_width` ticks is a vertical sync. It clears `line_o` to 0 and arms the trigger for the frame.
- R3: In one-pin mode, an active pulse on `te_a_i` lasting at least `hs_width` ticks but fewer than `vs_width` ticks is a horizontal sync. It advances `line_o` by exactly one. A pulse of exactly `vs_width - 1` ticks is still horizontal.
- R4: An active pulse shorter than the width its pin needs (`hs_width` on `te_a_i`, `vs_width` on `te_b_i` in two-pin mode) leaves `line_o` unchanged and produces no strobe.
- R5: In two-pin mode (`cfg_mode` = 2), `te_a_i` carries only horizontal sync and `te_b_i` carries only vertical sync. A long pulse on `te_a_i` still counts as one line.
- R6: In one-pin mode, activity on `te_b_i` has no effect on `line_o` or `start_o`.
- R7: `hs_pol_i` sets the sense of `te_a_i` and `vs_pol_i` sets the sense of `te_b_i`. A value of 1 means the pin is active high; 0 means active low with a high idle level.
- R8: `start_o` is high for exactly one cycle when an armed frame's line count becomes equal to `trig_line_i`. When `trig_line_i` is 0, it fires on the vertical sync itself. At that cycle `line_o` equals `trig_line_i`.
- R9: `start_o` fires at most once per vertical sync. It never fires before the first vertical sync that follows enabling.
- R10: With `cfg_mode` set to 0 or 3 (off), sync pulses are ignored. `line_o` reads 0, `start_o` stays low, and the trigger is disarmed.
- R11: `line_o` saturates at 2047. Further horizontal syncs neither wrap it nor fire a second strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; pulse widths are counted in its ticks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 off, 1 one-pin, 2 two-pin, 3 off |
| hs_width_i | input | 6 | Minimum horizontal sync width in ticks |
| vs_width_i | input | 6 | Minimum vertical sync width in ticks |
| hs_pol_i | input | 1 | 1: `te_a_i` active high, 0: active low |
| vs_pol_i | input | 1 | 1: `te_b_i` active high, 0: active low |
| trig_line_i | input | 11 | Line number at which the strobe fires |
| te_a_i | input | 1 | Asynchronous sync pin A (both syncs in one-pin mode, horizontal in two-pin mode) |
| te_b_i | input | 1 | Asynchronous sync pin B (vertical sync in two-pin mode) |
| line_o | output | 11 | Current line count since the last vertical sync |
| start_o | output | 1 | One-cycle transfer start strobe |

## Verification
The width classifier is driven with pulses at the exact edges of each class: `hs_width - 1`, `hs_width`, `vs_width - 1`, `vs_width`, and well above `vs_width`. This shows that both thresholds are inclusive where intended and that the two classes do not overlap. The same pulse lengths are then sent on each pin in each mode. This separates a block that routes pins by mode from one that merges them. Active-low pins confirm that the polarity selection is honoured rather than assumed.

The trigger is exercised with hsyncs before any vsync, with extra hsyncs after the match, with a line of zero, and with a run past 2047. These cases show the difference between a one-shot armed strobe and a plain equality compare.

// File: rtl/te_pkg.sv
package te_pkg;

    // Operating mode of the tearing-effect input stage
    typedef enum logic [1:0] {
        TE_MODE_OFF  = 2'd0,
        TE_MODE_ONE  = 2'd1,
        TE_MODE_TWO  = 2'd2,
        TE_MODE_RSVD = 2'd3
    } te_mode_e;

    localparam int unsigned TE_SYNC_STAGES = 2;

endpackage

// File: rtl/te_sync.sv
// Multi-flop synchronizer followed by polarity normalisation.
module te_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic active_high_i,
    output logic act_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o = st_q.sh[STAGES-1] ^ ~active_high_i;

endmodule

// File: rtl/te_pulse_meas.sv
// Counts the active duration of each pulse and reports it when the pulse ends.
module te_pulse_meas #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             act_i,
    output logic             done_o,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             idle_seen;
        logic             done;
        logic [CNT_W-1:0] len;
    } meas_st_t;

    meas_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!en_i) begin
            st_d.cnt       = '0;
            st_d.idle_seen = 1'b0;
        end else if (act_i) begin
            // a pulse already in progress at enable is not measured
            if (st_q.idle_seen && (st_q.cnt != CNT_MAX)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.idle_seen = 1'b1;
            if (st_q.cnt != '0) begin
                st_d.done = 1'b1;
                st_d.len  = st_q.cnt;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign len_o  = st_q.len;

endmodule

// File: rtl/te_line_ctr.sv
// Line counter with a one-shot trigger armed by each vertical sync.
module te_line_ctr #(
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              hs_evt_i,
    input  logic              vs_evt_i,
    input  logic [LINE_W-1:0] trig_line_i,
    output logic [LINE_W-1:0] line_o,
    output logic              start_o
);

    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              armed;
        logic              start;
    } ctr_st_t;

    ctr_st_t           st_d, st_q;
    logic [LINE_W-1:0] next_line;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        next_line  = (st_q.line == LINE_MAX) ? LINE_MAX : st_q.line + 1'b1;
        if (!en_i) begin
            st_d.line  = '0;
            st_d.armed = 1'b0;
        end else if (vs_evt_i) begin
            st_d.line = '0;
            if (trig_line_i == '0) begin
                st_d.start = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b1;
            end
        end else if (hs_evt_i) begin
            st_d.line = next_line;
            if (st_q.armed && (next_line == trig_line_i)) begin
                st_d.start = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o  = st_q.line;
    assign start_o = st_q.start;

endmodule

// File: rtl/te_line_trigger.sv
module te_line_trigger
    import te_pkg::*;
#(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  hs_width_i,
    input  logic [CNT_W-1:0]  vs_width_i,
    input  logic              hs_pol_i,
    input  logic              vs_pol_i,
    input  logic [LINE_W-1:0] trig_line_i,
    input  logic              te_a_i,
    input  logic              te_b_i,
    output logic [LINE_W-1:0] line_o,
    output logic              start_o
);

    localparam int unsigned NPIN = 2;

    te_mode_e mode;
    logic     one_pin, two_pin, enable;

    assign mode    = te_mode_e'(cfg_mode);
    assign one_pin = (mode == TE_MODE_ONE);
    assign two_pin = (mode == TE_MODE_TWO);
    assign enable  = one_pin | two_pin;

    logic [NPIN-1:0]  pin_raw, pin_pol, pin_en, pin_act, pin_done;
    logic [CNT_W-1:0] pin_len [NPIN];

    assign pin_raw = {te_b_i, te_a_i};
    assign pin_pol = {vs_pol_i, hs_pol_i};
    assign pin_en  = {two_pin, enable};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        te_sync #(
            .STAGES        (TE_SYNC_STAGES)
        ) u_sync (
            .clk           (clk),
            .rst_n         (rst_n),
            .raw_i         (pin_raw[i]),
            .active_high_i (pin_pol[i]),
            .act_o         (pin_act[i])
        );

        te_pulse_meas #(
            .CNT_W  (CNT_W)
        ) u_meas (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (pin_en[i]),
            .act_i  (pin_act[i]),
            .done_o (pin_done[i]),
            .len_o  (pin_len[i])
        );
    end

    typedef struct packed {
        logic hs;
        logic vs;
    } evt_t;

    evt_t evt;
    logic a_long, a_mid, b_long;

    always_comb begin
        a_long = pin_done[0] && (pin_len[0] >= vs_width_i);
        a_mid  = pin_done[0] && (pin_len[0] >= hs_width_i);
        b_long = pin_done[1] && (pin_len[1] >= vs_width_i);
        evt    = '0;
        if (one_pin) begin
            // vertical sync takes precedence when both thresholds are met
            evt.vs = a_long;
            evt.hs = a_mid && !a_long;
        end else if (two_pin) begin
            evt.vs = b_long;
            evt.hs = a_mid;
        end
    end

    te_line_ctr #(
        .LINE_W      (LINE_W)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (enable),
        .hs_evt_i    (evt.hs),
        .vs_evt_i    (evt.vs),
        .trig_line_i (trig_line_i),
        .line_o      (line_o),
        .start_o     (start_o)
    );

endmodule

// File: rtl/te_line_trigger_chk.sv
module te_line_trigger_chk #(
    parameter int unsigned LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_mode,
    input logic [LINE_W-1:0] trig_line_i,
    input logic [LINE_W-1:0] line_o,
    input logic              start_o
);

    localparam logic [LINE_W-1:0] LMAX = {LINE_W{1'b1}};

    logic mode_off;
    assign mode_off = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);

    // R8: strobe lasts a single cycle
    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R8: strobe coincides with the programmed line
    assert_start_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (line_o == trig_line_i));

    // R3: the count only steps by one or returns to zero
    assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |->
            ((line_o == LINE_W'($past(line_o) + 1'b1)) || (line_o == '0)));

    // R11: no wrap beyond the maximum line
    assert_line_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o == LMAX) |=> ((line_o == LMAX) || (line_o == '0)));

    // R10: off mode keeps the block quiet
    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_off |=> ((line_o == '0) && !start_o));

endmodule

bind te_line_trigger te_line_trigger_chk #(
    .LINE_W      (LINE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .trig_line_i (trig_line_i),
    .line_o      (line_o),
    .start_o     (start_o)
);

// File: tb/te_line_trigger_test.sv
module te_line_trigger_test;

    localparam int CLK_PERIOD = 10;
    localparam int HSW = 3;
    localparam int VSW = 6;
    localparam int NVEC = 12;
    localparam int GAP = 10;

    // fields: mode, pin (0=a,1=b), pulse length, expected line, expected strobes
    localparam int VEC [NVEC][5] = '{
        '{1, 0, 7, 0, 0},   // R2 long pulse -> vsync
        '{1, 0, 3, 1, 0},   // R3 exactly hs width
        '{1, 0, 2, 1, 0},   // R4 one tick short
        '{1, 0, 5, 2, 1},   // R3 vs width - 1 is hsync, R8 fires at line 2
        '{1, 0, 6, 0, 0},   // R2 exactly vs width
        '{1, 1, 4, 0, 0},   // R6 pin b ignored
        '{1, 0, 4, 1, 0},   // R3
        '{2, 1, 6, 0, 0},   // R5 vsync on pin b
        '{2, 0, 3, 1, 0},   // R5 hsync on pin a
        '{2, 0, 9, 2, 1},   // R5 long pulse on pin a is still a line, R8
        '{2, 1, 5, 2, 0},   // R4 short pulse on pin b
        '{2, 1, 6, 0, 0}    // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd1;
    logic [5:0]  hs_width = 6'(HSW);
    logic [5:0]  vs_width = 6'(VSW);
    logic        hs_pol = 1'b1;
    logic        vs_pol = 1'b1;
    logic [10:0] trig_line = 11'd2;
    logic        te_a = 1'b0;
    logic        te_b = 1'b0;
    logic [10:0] line_o;
    logic        start_o;

    int errors = 0;
    int checks = 0;
    int start_cnt = 0;
    int wide_cnt = 0;
    logic start_prev = 1'b0;
    bit finished = 1'b0;

    te_line_trigger uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (cfg_mode),
        .hs_width_i  (hs_width),
        .vs_width_i  (vs_width),
        .hs_pol_i    (hs_pol),
        .vs_pol_i    (vs_pol),
        .trig_line_i (trig_line),
        .te_a_i      (te_a),
        .te_b_i      (te_b),
        .line_o      (line_o),
        .start_o     (start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (start_o) start_cnt++;
        if (start_o && start_prev) wide_cnt++;
        start_prev <= start_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int pin, input int len, input int gap);
        logic lvl;
        lvl = (pin == 0) ? hs_pol : vs_pol;
        @(negedge clk);
        if (pin == 0) te_a = lvl; else te_b = lvl;
        repeat (len) @(negedge clk);
        if (pin == 0) te_a = ~lvl; else te_b = ~lvl;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int s0;
        // R1 reset state
        repeat (3) @(negedge clk);
        check(line_o == 0 && !start_o, "R1 during reset", int'(line_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(line_o == 0 && !start_o, "R1 after reset", int'(line_o), 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            cfg_mode = 2'(VEC[i][0]);
            s0 = start_cnt;
            pulse(VEC[i][1], VEC[i][2], GAP);
            check(int'(line_o) == VEC[i][3], $sformatf("R2-5 vector %0d line", i),
                  int'(line_o), VEC[i][3]);
            check(start_cnt - s0 == VEC[i][4], $sformatf("R8 vector %0d strobes", i),
                  start_cnt - s0, VEC[i][4]);
        end

        // R10 off modes ignore pulses and clear the count
        pulse(0, 3, GAP);  // line 1 in two-pin mode
        trig_line = 11'd1;
        cfg_mode = 2'd0;
        repeat (3) @(negedge clk);
        check(line_o == 0, "R10 off clears line", int'(line_o), 0);
        s0 = start_cnt;
        pulse(0, 7, GAP);
        pulse(0, 3, GAP);
        check(line_o == 0 && start_cnt == s0, "R10 mode 0 ignores pulses", int'(line_o), 0);
        cfg_mode = 2'd3;
        pulse(0, 3, GAP);
        pulse(1, 7, GAP);
        check(line_o == 0 && start_cnt == s0, "R10 mode 3 ignores pulses", int'(line_o), 0);

        // R9 no strobe before the first vsync after enabling
        cfg_mode = 2'd1;
        repeat (3) @(negedge clk);
        pulse(0, 3, GAP);
        check(line_o == 1, "R9 line counts unarmed", int'(line_o), 1);
        check(start_cnt == s0, "R9 no strobe unarmed", start_cnt - s0, 0);
        pulse(0, 7, GAP);
        pulse(0, 3, GAP);
        check(start_cnt - s0 == 1, "R8 strobe at line 1", start_cnt - s0, 1);
        pulse(0, 3, GAP);
        pulse(0, 3, GAP);
        check(line_o == 3 && start_cnt - s0 == 1, "R9 single strobe per frame",
              start_cnt - s0, 1);

        // R8 line zero fires on the vsync itself
        trig_line = 11'd0;
        s0 = start_cnt;
        pulse(0, 8, GAP);
        check(start_cnt - s0 == 1 && line_o == 0, "R8 strobe at line 0", start_cnt - s0, 1);

        // R7 active-low pins
        cfg_mode = 2'd0;
        repeat (2) @(negedge clk);
        hs_pol = 1'b0;
        vs_pol = 1'b0;
        te_a = 1'b1;
        te_b = 1'b1;
        repeat (5) @(negedge clk);
        cfg_mode = 2'd1;
        trig_line = 11'd5;
        repeat (3) @(negedge clk);
        pulse(0, 3, GAP);
        check(line_o == 1, "R7 active-low hsync", int'(line_o), 1);
        pulse(0, 7, GAP);
        check(line_o == 0, "R7 active-low vsync", int'(line_o), 0);
        pulse(0, 3, GAP);
        cfg_mode = 2'd2;
        repeat (3) @(negedge clk);
        pulse(1, 6, GAP);
        check(line_o == 0, "R7 active-low pin b vsync", int'(line_o), 0);
        cfg_mode = 2'd0;
        repeat (2) @(negedge clk);
        hs_pol = 1'b1;
        vs_pol = 1'b1;
        te_a = 1'b0;
        te_b = 1'b0;
        repeat (5) @(negedge clk);

        // R11 saturation at 2047
        cfg_mode = 2'd1;
        trig_line = 11'd2047;
        repeat (3) @(negedge clk);
        s0 = start_cnt;
        pulse(0, 7, GAP);
        for (int k = 0; k < 2050; k++) pulse(0, 3, 6);
        repeat (GAP) @(negedge clk);
        check(line_o == 11'd2047, "R11 line saturates", int'(line_o), 2047);
        check(start_cnt - s0 == 1, "R11 single strobe at max line", start_cnt - s0, 1);

        // R8 strobe width over the whole run
        check(wide_cnt == 0, "R8 strobe one cycle wide", wide_cnt, 0);

        finish_run();
    end

endmodule